// File: doc/BRIEF.md
# PLL Phase Alignment Calibrator

This controller brings the reference and feedback clocks of several PLL lanes (three by default) into phase, all lanes in parallel. For each lane it drives two delay codes, one on the reference path and one on the feedback path. It also drives a jitter-meter enable. When the meter is enabled it returns two counts: how often one clock sampled high on the other, and how often it sampled low. A start pulse launches a sequence of measurement rounds. In each round the block applies the delays, lets the loops settle, runs the meters, judges each lane and switches the meters off.

The first measurement fixes each lane's direction. A lane whose reference lags gets more feedback delay. A lane whose reference leads gets more reference delay. A lane that is already balanced is finished at once. From then on the chosen path only grows by one step per round, until the imbalance between the two counts falls within a threshold. The run ends with a done flag when every lane is aligned. It ends with a fail flag when a delay counter reaches 32 first. Either flag holds until the next start.

Top module: `pll_phase_cal`

## Requirements
- R1: After reset all delay codes are zero, meters are disabled, and both done and fail are low.
- R2: A start pulse seen while idle clears done, fail, every lane's phase state and every lane's delay, then begins a round. A start pulse while a run is in progress has no effect on its outcome or timing.
- R3: A round lasts SETTLE_CYC+METER_CYC+3 cycles. It runs as one apply cycle, then SETTLE_CYC settle cycles, then METER_CYC+1 cycles with every lane's meter enabled together (the last of these is the evaluation), then one cycle with all meters off.
- R4: A lane in its initial state drives zero on both paths. A lane in the lag state puts its delay on the feedback path with reference zero. A lane in the lead state puts it on the reference path with feedback zero. Both paths are never nonzero together.
- R5: On the first evaluation, a lane with ones minus zeros greater than THRESH goes to the lag state and steps its delay. A lane with zeros minus ones greater than THRESH goes to the lead state and steps its delay. Otherwise the lane is aligned. Differences are signed, so a negative difference never exceeds THRESH.
- R6: In the lag or lead state, a lane is aligned once its own difference is at most THRESH. Otherwise its delay grows by one per round.
- R7: An aligned lane keeps its delay codes unchanged for the rest of the run.
- R8: Done rises at the end of the round in which the last lane aligns. It stays high until the next start, with meters off.
- R9: If some lane's delay count reaches 32 before all lanes are aligned, fail rises at the end of that round (after 32 rounds), with the last applied code 31. Done and fail are never high together.
- R10: The sample-count output equals SAMPLE_CNT (1024 by default) at all times.
- R11: Delay codes never change while any meter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches calibration |
| jm_ones | input | NUM_LANES*CNT_W | Per-lane count of high samples, lane 0 in the low bits |
| jm_zeros | input | NUM_LANES*CNT_W | Per-lane count of low samples |
| jm_en | output | NUM_LANES | Per-lane meter enable |
| jm_samples | output | CNT_W | Sample count programmed into every meter |
| ref_dly | output | NUM_LANES*DLY_W | Per-lane reference-path delay code |
| fb_dly | output | NUM_LANES*DLY_W | Per-lane feedback-path delay code |
| cal_done | output | 1 | All lanes aligned |
| cal_fail | output | 1 | A delay counter reached 32 |

## Verification
With the start pulse taken at edge 0, round k ends at edge k*(SETTLE_CYC+METER_CYC+3), and the done or fail flag is visible right after the edge that closes the last round. The enable rises once per round, SETTLE_CYC+1 edges after that round's start. The scoreboard predicts the number of rounds, which flag rises and the final codes of each lane. The monitor counts edges from the capturing edge, samples on the falling edge and compares both the exact cycle of the flag and the number of enable rises. It also checks every cycle that no code moves while the enable is high.

// File: rtl/pll_cal_pkg.sv
package pll_cal_pkg;

   // Per-lane alignment state
   typedef enum logic [1:0] {
      PH_INIT = 2'd0,
      PH_LAG  = 2'd1,
      PH_LEAD = 2'd2
   } lane_phase_e;

   // Round sequencer state
   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_APPLY  = 3'd1,
      SQ_SETTLE = 3'd2,
      SQ_MEAS   = 3'd3,
      SQ_EVAL   = 3'd4,
      SQ_CHECK  = 3'd5
   } seq_state_e;

endpackage

// File: rtl/pll_cal_seq.sv
module pll_cal_seq
   import pll_cal_pkg::*;
#(
   parameter int NUM_LANES  = 3,
   parameter int SETTLE_CYC = 2000,
   parameter int METER_CYC  = 1100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NUM_LANES-1:0] lanes_done,
   input  logic [NUM_LANES-1:0] lanes_ovf,
   output logic                 clear_pulse,
   output logic                 apply_pulse,
   output logic                 eval_pulse,
   output logic                 meter_on,
   output logic                 cal_done,
   output logic                 cal_fail
);

   localparam int MAX_WAIT = (SETTLE_CYC > METER_CYC) ? SETTLE_CYC : METER_CYC;
   localparam int TMR_W    = $clog2(MAX_WAIT + 1);
   localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
   localparam logic [TMR_W-1:0] METER_LAST  = TMR_W'(METER_CYC - 1);

   seq_state_e       st_q;
   logic [TMR_W-1:0] tmr_q;

   assign clear_pulse = (st_q == SQ_IDLE) && start;
   assign apply_pulse = (st_q == SQ_APPLY);
   assign eval_pulse  = (st_q == SQ_EVAL);
   assign meter_on    = (st_q == SQ_MEAS) || (st_q == SQ_EVAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         tmr_q    <= '0;
         cal_done <= 1'b0;
         cal_fail <= 1'b0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q     <= SQ_APPLY;
                  cal_done <= 1'b0;
                  cal_fail <= 1'b0;
               end
            end
            SQ_APPLY: begin
               st_q  <= SQ_SETTLE;
               tmr_q <= '0;
            end
            SQ_SETTLE: begin
               if (tmr_q == SETTLE_LAST) begin
                  st_q  <= SQ_MEAS;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            SQ_MEAS: begin
               if (tmr_q == METER_LAST) begin
                  st_q <= SQ_EVAL;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            SQ_EVAL: st_q <= SQ_CHECK;
            SQ_CHECK: begin
               if (&lanes_done) begin
                  cal_done <= 1'b1;
                  st_q     <= SQ_IDLE;
               end else if (|lanes_ovf) begin
                  cal_fail <= 1'b1;
                  st_q     <= SQ_IDLE;
               end else begin
                  st_q <= SQ_APPLY;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pll_cal_lane.sv
module pll_cal_lane
   import pll_cal_pkg::*;
#(
   parameter int DLY_W  = 5,
   parameter int CNT_W  = 16,
   parameter int THRESH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             apply,
   input  logic             eval,
   input  logic [CNT_W-1:0] ones,
   input  logic [CNT_W-1:0] zeros,
   output logic [DLY_W-1:0] ref_dly,
   output logic [DLY_W-1:0] fb_dly,
   output logic             lane_done,
   output logic             lane_ovf
);

   localparam int DIFF_W = CNT_W + 1;
   localparam logic signed [DIFF_W-1:0] THR = DIFF_W'(THRESH);

   lane_phase_e              ph_q;
   logic [DLY_W:0]           dly_q;
   logic signed [DIFF_W-1:0] ones_s, zeros_s, lag_diff, lead_diff;
   logic                     lag_big, lead_big;

   assign ones_s    = signed'({1'b0, ones});
   assign zeros_s   = signed'({1'b0, zeros});
   assign lag_diff  = ones_s - zeros_s;
   assign lead_diff = zeros_s - ones_s;
   assign lag_big   = lag_diff > THR;
   assign lead_big  = lead_diff > THR;
   assign lane_ovf  = dly_q[DLY_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_INIT;
         dly_q     <= '0;
         lane_done <= 1'b0;
         ref_dly   <= '0;
         fb_dly    <= '0;
      end else if (clear) begin
         ph_q      <= PH_INIT;
         dly_q     <= '0;
         lane_done <= 1'b0;
         ref_dly   <= '0;
         fb_dly    <= '0;
      end else if (apply && !lane_done) begin
         case (ph_q)
            PH_LAG: begin
               ref_dly <= '0;
               fb_dly  <= dly_q[DLY_W-1:0];
            end
            PH_LEAD: begin
               ref_dly <= dly_q[DLY_W-1:0];
               fb_dly  <= '0;
            end
            default: begin
               ref_dly <= '0;
               fb_dly  <= '0;
            end
         endcase
      end else if (eval && !lane_done) begin
         case (ph_q)
            PH_INIT: begin
               if (lag_big) begin
                  ph_q  <= PH_LAG;
                  dly_q <= dly_q + 1'b1;
               end else if (lead_big) begin
                  ph_q  <= PH_LEAD;
                  dly_q <= dly_q + 1'b1;
               end else begin
                  lane_done <= 1'b1;
               end
            end
            PH_LAG: begin
               if (lag_big) dly_q <= dly_q + 1'b1;
               else         lane_done <= 1'b1;
            end
            PH_LEAD: begin
               if (lead_big) dly_q <= dly_q + 1'b1;
               else          lane_done <= 1'b1;
            end
            default: lane_done <= 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/pll_phase_cal.sv
module pll_phase_cal
   import pll_cal_pkg::*;
#(
   parameter int NUM_LANES  = 3,
   parameter int DLY_W      = 5,
   parameter int CNT_W      = 16,
   parameter int SAMPLE_CNT = 1024,
   parameter int THRESH     = 16,
   parameter int SETTLE_CYC = 2000,
   parameter int METER_CYC  = 1100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [NUM_LANES*CNT_W-1:0] jm_ones,
   input  logic [NUM_LANES*CNT_W-1:0] jm_zeros,
   output logic [NUM_LANES-1:0]       jm_en,
   output logic [CNT_W-1:0]           jm_samples,
   output logic [NUM_LANES*DLY_W-1:0] ref_dly,
   output logic [NUM_LANES*DLY_W-1:0] fb_dly,
   output logic                       cal_done,
   output logic                       cal_fail
);

   // Elaboration-time parameter checks
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end
   if (SAMPLE_CNT >= (2 ** CNT_W)) begin : g_bad_cnt
      $error("SAMPLE_CNT does not fit in CNT_W bits");
   end
   if (THRESH < 0 || THRESH >= SAMPLE_CNT) begin : g_bad_thr
      $error("THRESH must lie in 0 .. SAMPLE_CNT-1");
   end
   if (SETTLE_CYC < 1 || METER_CYC < 1) begin : g_bad_wait
      $error("wait times must be at least one cycle");
   end

   logic                 seq_clear, seq_apply, seq_eval, seq_meter_on;
   logic [NUM_LANES-1:0] lane_done, lane_ovf;

   assign jm_samples = CNT_W'(SAMPLE_CNT);

   pll_cal_seq #(
      .NUM_LANES  (NUM_LANES),
      .SETTLE_CYC (SETTLE_CYC),
      .METER_CYC  (METER_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .lanes_done  (lane_done),
      .lanes_ovf   (lane_ovf),
      .clear_pulse (seq_clear),
      .apply_pulse (seq_apply),
      .eval_pulse  (seq_eval),
      .meter_on    (seq_meter_on),
      .cal_done    (cal_done),
      .cal_fail    (cal_fail)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign jm_en[g] = seq_meter_on;

      pll_cal_lane #(
         .DLY_W  (DLY_W),
         .CNT_W  (CNT_W),
         .THRESH (THRESH)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (seq_clear),
         .apply     (seq_apply),
         .eval      (seq_eval),
         .ones      (jm_ones[g*CNT_W +: CNT_W]),
         .zeros     (jm_zeros[g*CNT_W +: CNT_W]),
         .ref_dly   (ref_dly[g*DLY_W +: DLY_W]),
         .fb_dly    (fb_dly[g*DLY_W +: DLY_W]),
         .lane_done (lane_done[g]),
         .lane_ovf  (lane_ovf[g])
      );
   end

endmodule

// File: rtl/pll_cal_chk.sv
module pll_cal_chk #(
   parameter int NUM_LANES = 3,
   parameter int DLY_W     = 5
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [NUM_LANES-1:0]       jm_en,
   input logic [NUM_LANES*DLY_W-1:0] ref_dly,
   input logic [NUM_LANES*DLY_W-1:0] fb_dly,
   input logic                       cal_done,
   input logic                       cal_fail
);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_path
      // R4: only one path carries delay
      assert_one_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !((ref_dly[g*DLY_W +: DLY_W] != '0) && (fb_dly[g*DLY_W +: DLY_W] != '0)));
   end

   // R3: meters are switched as a group
   assert_meters_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (jm_en == '0) || (jm_en == '1));

   // R11: codes stay put while measuring
   assert_codes_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (jm_en != '0) |=> ($stable(ref_dly) && $stable(fb_dly)));

   // R9: outcomes are exclusive
   assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_done && cal_fail));

   // R8: done holds until a new start
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !start) |=> cal_done);

   // R9: fail holds until a new start
   assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_fail && !start) |=> cal_fail);

   // R8: meters are off once the run has ended
   assert_idle_meter_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done || cal_fail) |-> (jm_en == '0));

endmodule

bind pll_phase_cal pll_cal_chk #(
   .NUM_LANES (NUM_LANES),
   .DLY_W     (DLY_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .jm_en    (jm_en),
   .ref_dly  (ref_dly),
   .fb_dly   (fb_dly),
   .cal_done (cal_done),
   .cal_fail (cal_fail)
);

// File: tb/test_pll_phase_cal.sv
module test_pll_phase_cal;

   localparam int NL  = 3;
   localparam int DW  = 5;
   localparam int CW  = 16;
   localparam int SC  = 1024;
   localparam int THR = 16;
   localparam int ST  = 8;
   localparam int MT  = 5;
   localparam int RND = ST + MT + 3;

   typedef struct packed {
      logic          fail;
      logic [7:0]    iters;
      logic [NL*DW-1:0] rd;
      logic [NL*DW-1:0] fd;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NL*CW-1:0] ones_bus, zeros_bus;
   logic [NL-1:0]    jm_en;
   logic [CW-1:0]    jm_samples;
   logic [NL*DW-1:0] ref_dly, fb_dly;
   logic             cal_done, cal_fail;

   int   mt[NL];
   int   mb[NL];
   exp_t sb_q[$];
   int   checks = 0;
   int   errors = 0;
   int   results = 0;

   always #5 clk = ~clk;

   pll_phase_cal #(
      .NUM_LANES(NL), .DLY_W(DW), .CNT_W(CW), .SAMPLE_CNT(SC),
      .THRESH(THR), .SETTLE_CYC(ST), .METER_CYC(MT)
   ) i_pll_phase_cal (
      .clk(clk), .rst_n(rst_n), .start(start),
      .jm_ones(ones_bus), .jm_zeros(zeros_bus),
      .jm_en(jm_en), .jm_samples(jm_samples),
      .ref_dly(ref_dly), .fb_dly(fb_dly),
      .cal_done(cal_done), .cal_fail(cal_fail)
   );

   // Meter/PLL model: skew = offset + ref - fb, ones = 512 + 32*skew + bias
   function automatic int model_ones(int t, int b, int r, int f);
      int raw;
      raw = SC / 2 + 32 * (t + r - f) + b;
      if (raw < 0) raw = 0;
      if (raw > SC) raw = SC;
      return raw;
   endfunction

   always_comb begin
      for (int i = 0; i < NL; i++) begin
         if (jm_en[i]) begin
            ones_bus[i*CW +: CW]  = CW'(model_ones(mt[i], mb[i],
                                    int'(ref_dly[i*DW +: DW]), int'(fb_dly[i*DW +: DW])));
            zeros_bus[i*CW +: CW] = CW'(SC - model_ones(mt[i], mb[i],
                                    int'(ref_dly[i*DW +: DW]), int'(fb_dly[i*DW +: DW])));
         end else begin
            ones_bus[i*CW +: CW]  = '0;
            zeros_bus[i*CW +: CW] = '0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Driver: predicts the outcome from the requirements, queues it, pulses start
   task automatic run_case(input int t0, input int t1, input int t2,
                           input int b0, input int b1, input int b2,
                           input bit extra_start);
      exp_t e;
      int   tv[NL];
      int   bv[NL];
      int   seen;
      tv[0] = t0; tv[1] = t1; tv[2] = t2;
      bv[0] = b0; bv[1] = b1; bv[2] = b2;
      e = '0;
      for (int i = 0; i < NL; i++) begin
         int r, f, it;
         r = 0; f = 0; it = 1;
         mt[i] = tv[i]; mb[i] = bv[i];
         if (tv[i] >= 32)        begin f = 31; it = 32; e.fail = 1'b1; end
         else if (tv[i] <= -32)  begin r = 31; it = 32; e.fail = 1'b1; end
         else if (tv[i] > 0)     begin f = tv[i];  it = tv[i] + 1; end
         else if (tv[i] < 0)     begin r = -tv[i]; it = -tv[i] + 1; end
         else if (2 * bv[i] > THR)  begin f = 1; it = 2; end
         else if (-2 * bv[i] > THR) begin r = 1; it = 2; end
         if (it > int'(e.iters)) e.iters = 8'(it);
         e.rd[i*DW +: DW] = DW'(r);
         e.fd[i*DW +: DW] = DW'(f);
      end
      if (e.fail) e.iters = 8'd32;
      sb_q.push_back(e);
      seen = results;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (extra_start) begin
         repeat (20) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      wait (results == seen + 1);
      repeat (4) @(negedge clk);
      // R8/R9: outcome flag still held, meters off
      chk(e.fail ? cal_fail : cal_done, "R8 R9 outcome held", int'(e.fail ? cal_fail : cal_done), 1);
      chk(jm_en == '0, "R8 meters off after run", int'(jm_en), 0);
   endtask

   // Monitor: follows one run from the capturing edge and compares with the queue
   initial begin
      forever begin
         exp_t e;
         int   cyc, rises;
         bit   prev_en, moved;
         logic [NL*DW-1:0] pr, pf;
         wait (sb_q.size() != 0);
         @(posedge clk iff start);
         cyc = 0; rises = 0; prev_en = 1'b0; moved = 1'b0;
         pr = ref_dly; pf = fb_dly;
         forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1)
               chk(!cal_done && !cal_fail, "R2 start clears outcome",
                   int'({cal_done, cal_fail}), 0);
            if (jm_en[0] && !prev_en) rises++;
            if (jm_en[0] && (ref_dly != pr || fb_dly != pf)) moved = 1'b1;
            prev_en = jm_en[0];
            pr = ref_dly; pf = fb_dly;
            if (cal_done || cal_fail || cyc > 40 * RND) break;
         end
         e = sb_q.pop_front();
         chk(cal_fail == e.fail, "R8 R9 fail flag", int'(cal_fail), int'(e.fail));
         chk(cal_done == !e.fail, "R8 R9 done flag", int'(cal_done), int'(!e.fail));
         chk(cyc == int'(e.iters) * RND, "R2 R3 cycles to outcome", cyc, int'(e.iters) * RND);
         chk(rises == int'(e.iters), "R3 R6 meter rounds", rises, int'(e.iters));
         chk(!moved, "R11 codes moved while measuring", int'(moved), 0);
         for (int i = 0; i < NL; i++) begin
            chk(ref_dly[i*DW +: DW] == e.rd[i*DW +: DW], "R4 R5 R6 R7 ref code",
                int'(ref_dly[i*DW +: DW]), int'(e.rd[i*DW +: DW]));
            chk(fb_dly[i*DW +: DW] == e.fd[i*DW +: DW], "R4 R5 R6 R7 fb code",
                int'(fb_dly[i*DW +: DW]), int'(e.fd[i*DW +: DW]));
         end
         results++;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin mt[i] = 0; mb[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cal_done == 1'b0 && cal_fail == 1'b0, "R1 flags low", int'({cal_done, cal_fail}), 0);
      chk(jm_en == '0, "R1 meters off", int'(jm_en), 0);
      chk(ref_dly == '0 && fb_dly == '0, "R1 codes zero", int'(ref_dly | fb_dly), 0);
      chk(jm_samples == CW'(SC), "R10 sample count", int'(jm_samples), SC);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R5: all balanced, aligned after one round
      run_case(0, 0, 0, 0, 0, 0, 1'b0);
      // R4 R6 R7: lag, lead and a lane at exactly THRESH
      run_case(3, -5, 0, 4, -6, 8, 1'b0);
      // R5: imbalance just above THRESH either way; negative difference in lag
      run_case(0, 0, 1, 9, -9, 0, 1'b0);
      // R9: one lane overflows
      run_case(40, 2, -1, 0, 0, 0, 1'b0);
      // R6 boundary: code 31 reached on both paths without failing
      run_case(-31, 31, 7, 0, 0, 0, 1'b0);
      // R2: start during a run is ignored
      run_case(3, -5, 0, 4, -6, 8, 1'b1);
      // R9: overflow on the reference path with saturated counts
      run_case(0, -36, 5, 0, 0, 0, 1'b0);
      chk(jm_samples == CW'(SC), "R10 sample count after runs", int'(jm_samples), SC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule